// File: doc/BRIEF.md
# Transactional Abort Control Unit

This unit sits in a processor front end and keeps the bookkeeping for hardware transactions. Decoded pulses for transaction begin, transaction end and the explicit abort instruction (opcode bytes C6 F8 followed by an 8-bit immediate) arrive one per cycle. The unit tracks whether a transaction is live, counts how deeply begins are nested, and holds the fallback address that the outermost begin supplied.

When an abort is taken, either because the explicit abort instruction ran inside a transaction or because a begin would nest too deeply, the unit flattens all nesting in one step. It then emits a redirect to the held fallback address, a 32-bit status word for the accumulator, and single-cycle requests to restore the register snapshot and to drop the buffered stores. An abort outside a transaction does nothing. An abort with the feature disabled or with a LOCK prefix raises an invalid-opcode fault instead. Register checkpointing and store buffering live elsewhere in the core. All outputs are registered and change on the clock edge that samples the pulse.

Top module: `tac_ctrl`

## Requirements
- R1: A taken begin raises the nesting depth by one. The begin that moves the depth from 0 to 1 sets the active flag and captures `begin_fallback_i`. Inner begins leave the held fallback address unchanged.
- R2: A taken end lowers the depth by one. When the depth reaches 0, the active flag clears and `commit_o` pulses for one cycle with no redirect. An end while idle changes nothing.
- R3: A valid abort while idle is a no-op: no redirect, no status, no restore or discard request, no fault, and depth and active are unchanged.
- R4: A valid abort while active leaves depth 0 and active 0 on the next cycle, whatever the depth was.
- R5: The status of an explicit abort carries the immediate in bits 31:24 and has bit 0 (explicit-abort cause) set. All other bits are 0. `status_o` is 0 whenever `status_valid_o` is low.
- R6: The redirect target is the address captured by the outermost begin, never one offered by a nested begin.
- R7: With `long_mode_i` high at the abort, all 64 bits of the fallback address are driven. With it low, bits 63:32 of `redirect_addr_o` are 0 and bits 31:0 carry the low half. The address is 0 while `redirect_valid_o` is low.
- R8: An abort pulse with `feat_en_i` low or `lock_pfx_i` high pulses `ud_fault_o`. No abort processing follows and depth and active stay unchanged.
- R9: Every taken abort pulses `restore_regs_o` and `discard_stores_o` for exactly one cycle, together with `redirect_valid_o` and `status_valid_o`.
- R10: A begin at depth 7 (MAX_DEPTH) is not taken. It performs an abort whose status has bit 5 (nesting-overflow cause) set and every other bit, including the top byte, 0.
- R11: Outputs appear one clock after the pulse. When pulses coincide, abort wins over end and end wins over begin; the losing pulses are dropped.
- R12: After reset, depth, active and all pulse outputs are 0. Depth never exceeds MAX_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin_i | input | 1 | Decoded transaction-begin pulse |
| tx_end_i | input | 1 | Decoded transaction-end pulse |
| tx_abort_i | input | 1 | Decoded explicit-abort pulse |
| abort_code_i | input | 8 | Immediate byte of the abort instruction |
| lock_pfx_i | input | 1 | LOCK prefix seen on the abort instruction |
| feat_en_i | input | 1 | Transactional feature enabled |
| long_mode_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| begin_fallback_i | input | 64 | Fallback address offered with a begin |
| active_o | output | 1 | Transaction live |
| depth_o | output | 3 | Current nesting depth |
| redirect_valid_o | output | 1 | Redirect request |
| redirect_addr_o | output | 64 | Redirect target |
| status_valid_o | output | 1 | Accumulator status write request |
| status_o | output | 32 | Abort status word |
| restore_regs_o | output | 1 | Restore register snapshot request |
| discard_stores_o | output | 1 | Drop buffered stores request |
| ud_fault_o | output | 1 | Invalid-opcode fault |
| commit_o | output | 1 | Outermost end committed |

## Verification
The main function is driven with random mixes of begin, end and abort pulses that reach every nesting depth, so aborts land at shallow and deep nesting as well as while idle. This separates the flatten-to-zero path from a plain decrement and from the idle no-op. Fallback addresses with random upper halves, under both mode settings, show whether the outermost capture was kept and whether the upper half was masked. Directed cases drive a begin at depth 7, aborts with the LOCK prefix or with the feature off while a transaction is live, and coinciding pulses. These tell overflow status from explicit status, a fault from an abort, and the precedence order.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int ADDR_W   = 64;
  localparam int NARROW_W = 32;
  localparam int CODE_W   = 8;
  localparam int STAT_W   = 32;
  localparam int CAUSE_EXPLICIT = 0;
  localparam int CAUSE_NEST_OVF = 5;

  // status word for a taken abort
  function automatic logic [STAT_W-1:0] abort_status(input logic [CODE_W-1:0] code,
                                                     input logic nest_ovf);
    logic [STAT_W-1:0] s;
    s = '0;
    if (nest_ovf) begin
      s[CAUSE_NEST_OVF] = 1'b1;
    end else begin
      s[STAT_W-1 -: CODE_W] = code;
      s[CAUSE_EXPLICIT]     = 1'b1;
    end
    return s;
  endfunction

  // redirect target width follows the execution mode
  function automatic logic [ADDR_W-1:0] mode_target(input logic [ADDR_W-1:0] addr,
                                                    input logic wide);
    logic [ADDR_W-1:0] t;
    t = '0;
    if (wide) t = addr;
    else      t[NARROW_W-1:0] = addr[NARROW_W-1:0];
    return t;
  endfunction
endpackage

// File: rtl/tac_nest.sv
module tac_nest #(
  parameter int MAX_DEPTH = 7,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               open_i,
  input  logic               close_i,
  input  logic               flush_i,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               active_o,
  output logic               empty_o,
  output logic               last_o,
  output logic               full_o
);
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(MAX_DEPTH);
  localparam logic [DEPTH_W-1:0] ONE  = DEPTH_W'(1);

  logic [DEPTH_W-1:0] depth_q;
  logic               active_q;

  assign empty_o = (depth_q == '0);
  assign last_o  = (depth_q == ONE);
  assign full_o  = (depth_q == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q  <= '0;
      active_q <= 1'b0;
    end else if (flush_i) begin
      depth_q  <= '0;
      active_q <= 1'b0;
    end else if (close_i) begin
      depth_q <= depth_q - ONE;
      if (last_o) active_q <= 1'b0;
    end else if (open_i) begin
      depth_q <= depth_q + ONE;
      if (empty_o) active_q <= 1'b1;
    end
  end

  assign depth_o  = depth_q;
  assign active_o = active_q;
endmodule

// File: rtl/tac_fallback.sv
module tac_fallback #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] held_o
);
  logic [ADDR_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         held_q <= '0;
    else if (capture_i) held_q <= addr_i;
  end

  assign held_o = held_q;
endmodule

// File: rtl/tac_resp.sv
module tac_resp
  import tac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_abort_i,
  input  logic              nest_ovf_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] fallback_i,
  input  logic              fault_i,
  input  logic              commit_i,
  output logic              redirect_valid_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  output logic              status_valid_o,
  output logic [STAT_W-1:0] status_o,
  output logic              restore_o,
  output logic              discard_o,
  output logic              fault_o,
  output logic              commit_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid_o <= 1'b0;
      redirect_addr_o  <= '0;
      status_valid_o   <= 1'b0;
      status_o         <= '0;
      restore_o        <= 1'b0;
      discard_o        <= 1'b0;
      fault_o          <= 1'b0;
      commit_o         <= 1'b0;
    end else begin
      redirect_valid_o <= take_abort_i;
      redirect_addr_o  <= take_abort_i ? mode_target(fallback_i, wide_i) : '0;
      status_valid_o   <= take_abort_i;
      status_o         <= take_abort_i ? abort_status(code_i, nest_ovf_i) : '0;
      restore_o        <= take_abort_i;
      discard_o        <= take_abort_i;
      fault_o          <= fault_i;
      commit_o         <= commit_i;
    end
  end
endmodule

// File: rtl/tac_ctrl.sv
module tac_ctrl
  import tac_pkg::*;
#(
  parameter int MAX_DEPTH = 7,
  localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_begin_i,
  input  logic               tx_end_i,
  input  logic               tx_abort_i,
  input  logic [CODE_W-1:0]  abort_code_i,
  input  logic               lock_pfx_i,
  input  logic               feat_en_i,
  input  logic               long_mode_i,
  input  logic [ADDR_W-1:0]  begin_fallback_i,
  output logic               active_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               redirect_valid_o,
  output logic [ADDR_W-1:0]  redirect_addr_o,
  output logic               status_valid_o,
  output logic [STAT_W-1:0]  status_o,
  output logic               restore_regs_o,
  output logic               discard_stores_o,
  output logic               ud_fault_o,
  output logic               commit_o
);
  logic               empty_w, last_w, full_w, active_w;
  logic [DEPTH_W-1:0] depth_w;
  logic [ADDR_W-1:0]  fallback_w;

  // named internal events
  logic ev_fault, ev_explicit, ev_idle_nop, ev_end, ev_ovf, ev_open;
  logic ev_take_abort, ev_commit, ev_capture;

  assign ev_fault      = tx_abort_i && (!feat_en_i || lock_pfx_i);
  assign ev_explicit   = tx_abort_i && !ev_fault && active_w;
  assign ev_idle_nop   = tx_abort_i && !ev_fault && !active_w;
  assign ev_end        = tx_end_i && !tx_abort_i && active_w;
  assign ev_ovf        = tx_begin_i && !tx_abort_i && !tx_end_i && active_w && full_w;
  assign ev_open       = tx_begin_i && !tx_abort_i && !tx_end_i && !ev_ovf;
  assign ev_take_abort = ev_explicit || ev_ovf;
  assign ev_commit     = ev_end && last_w;
  assign ev_capture    = ev_open && empty_w;

  tac_nest #(.MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)) u_nest (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_i   (ev_open),
    .close_i  (ev_end),
    .flush_i  (ev_take_abort),
    .depth_o  (depth_w),
    .active_o (active_w),
    .empty_o  (empty_w),
    .last_o   (last_w),
    .full_o   (full_w)
  );

  tac_fallback #(.ADDR_W(ADDR_W)) u_fb (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (ev_capture),
    .addr_i    (begin_fallback_i),
    .held_o    (fallback_w)
  );

  tac_resp u_resp (
    .clk              (clk),
    .rst_n            (rst_n),
    .take_abort_i     (ev_take_abort),
    .nest_ovf_i       (ev_ovf),
    .code_i           (abort_code_i),
    .wide_i           (long_mode_i),
    .fallback_i       (fallback_w),
    .fault_i          (ev_fault),
    .commit_i         (ev_commit),
    .redirect_valid_o (redirect_valid_o),
    .redirect_addr_o  (redirect_addr_o),
    .status_valid_o   (status_valid_o),
    .status_o         (status_o),
    .restore_o        (restore_regs_o),
    .discard_o        (discard_stores_o),
    .fault_o          (ud_fault_o),
    .commit_o         (commit_o)
  );

  assign active_o = active_w;
  assign depth_o  = depth_w;
endmodule

// File: rtl/tac_ctrl_chk.sv
module tac_ctrl_chk
  import tac_pkg::*;
#(
  parameter int MAX_DEPTH = 7,
  parameter int DEPTH_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_explicit,
  input logic               ev_idle_nop,
  input logic               ev_ovf,
  input logic               ev_fault,
  input logic               ev_capture,
  input logic               long_mode_i,
  input logic               active_o,
  input logic [DEPTH_W-1:0] depth_o,
  input logic               redirect_valid_o,
  input logic [ADDR_W-1:0]  redirect_addr_o,
  input logic               status_valid_o,
  input logic [STAT_W-1:0]  status_o,
  input logic               restore_regs_o,
  input logic               discard_stores_o,
  input logic               ud_fault_o,
  input logic               commit_o
);
  // R4
  flatten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_explicit || ev_ovf) |=> (depth_o == '0) && !active_o);

  // R3
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle_nop |=> $stable(depth_o) && !redirect_valid_o && !status_valid_o);

  // R8
  fault_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> $stable(depth_o) && $stable(active_o) && !redirect_valid_o && !restore_regs_o);

  // R1
  first_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> active_o && (depth_o == DEPTH_W'(1)));

  // R7
  narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o && !$past(long_mode_i) |-> (redirect_addr_o[ADDR_W-1:NARROW_W] == '0));

  // R10
  ovf_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> status_valid_o && status_o[CAUSE_NEST_OVF] && (status_o[STAT_W-1 -: CODE_W] == '0));

  // R9
  cleanup_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> restore_regs_o && discard_stores_o && status_valid_o);

  // R12
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_o <= DEPTH_W'(MAX_DEPTH)) && (active_o == (depth_o != '0)));

  // R2
  commit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> !redirect_valid_o && !active_o);
endmodule

bind tac_ctrl tac_ctrl_chk #(.MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .ev_explicit      (ev_explicit),
  .ev_idle_nop      (ev_idle_nop),
  .ev_ovf           (ev_ovf),
  .ev_fault         (ev_fault),
  .ev_capture       (ev_capture),
  .long_mode_i      (long_mode_i),
  .active_o         (active_o),
  .depth_o          (depth_o),
  .redirect_valid_o (redirect_valid_o),
  .redirect_addr_o  (redirect_addr_o),
  .status_valid_o   (status_valid_o),
  .status_o         (status_o),
  .restore_regs_o   (restore_regs_o),
  .discard_stores_o (discard_stores_o),
  .ud_fault_o       (ud_fault_o),
  .commit_o         (commit_o)
);

// File: tb/sim_tac_ctrl.sv
module sim_tac_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_i = 0, e_i = 0, a_i = 0, lk_i = 0, fe_i = 1, m64_i = 1;
  logic [7:0]  code_i = 0;
  logic [63:0] fb_i = 0;
  logic        act_o, rv_o, sv_o, rr_o, ds_o, ud_o, cm_o;
  logic [2:0]  dep_o;
  logic [63:0] ra_o;
  logic [31:0] st_o;

  int checks = 0, fails = 0;

  // bench model state
  logic        m_act = 0;
  int          m_dep = 0;
  logic [63:0] m_fb = 0;

  always #4 clk = ~clk;

  tac_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tx_begin_i(b_i), .tx_end_i(e_i), .tx_abort_i(a_i),
    .abort_code_i(code_i), .lock_pfx_i(lk_i), .feat_en_i(fe_i), .long_mode_i(m64_i),
    .begin_fallback_i(fb_i), .active_o(act_o), .depth_o(dep_o),
    .redirect_valid_o(rv_o), .redirect_addr_o(ra_o), .status_valid_o(sv_o),
    .status_o(st_o), .restore_regs_o(rr_o), .discard_stores_o(ds_o),
    .ud_fault_o(ud_o), .commit_o(cm_o)
  );

  function automatic logic [31:0] exp_status(input logic [7:0] c, input logic ovf);
    return ovf ? 32'h0000_0020 : ((32'(c) << 24) | 32'h1);
  endfunction

  function automatic logic [63:0] exp_target(input logic [63:0] a, input logic wide);
    return wide ? a : (a & 64'h0000_0000_FFFF_FFFF);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of inputs at a negedge, compare at the next negedge
  task automatic op(input logic b, input logic e, input logic a, input logic [7:0] c,
                    input logic lk, input logic fe, input logic wide, input logic [63:0] fb);
    logic ud, xab, endv, ovf, beg, take, cmt;
    string tg;
    logic [63:0] x_addr;
    logic [31:0] x_st;
    b_i = b; e_i = e; a_i = a; code_i = c; lk_i = lk; fe_i = fe; m64_i = wide; fb_i = fb;
    ud   = a && (!fe || lk);
    xab  = a && !ud && m_act;
    endv = e && !a && m_act;
    ovf  = b && !a && !e && m_act && (m_dep == 7);
    beg  = b && !a && !e && !ovf;
    take = xab || ovf;
    cmt  = endv && (m_dep == 1);
    x_addr = take ? exp_target(m_fb, wide) : 64'h0;
    x_st   = take ? exp_status(c, ovf) : 32'h0;
    if (ovf) tg = "R10"; else if (xab) tg = "R4"; else if (ud) tg = "R8";
    else if (a) tg = "R3"; else if (endv) tg = "R2"; else if (b) tg = "R1"; else tg = "R11";
    // model update
    if (take) begin m_dep = 0; m_act = 0; end
    else if (endv) begin m_dep--; if (m_dep == 0) m_act = 0; end
    else if (beg) begin
      if (m_dep == 0) begin m_act = 1; m_fb = fb; end
      m_dep++;
    end
    @(negedge clk);
    chk(dep_o == 3'(m_dep), tg, 64'(dep_o), 64'(m_dep));
    chk(act_o == m_act, tg, 64'(act_o), 64'(m_act));
    chk(rv_o == take && sv_o == take, tg, 64'({rv_o, sv_o}), 64'({take, take}));
    chk(ra_o == x_addr, "R7", ra_o, x_addr);
    chk(st_o == x_st, "R5", 64'(st_o), 64'(x_st));
    chk(rr_o == take && ds_o == take, "R9", 64'({rr_o, ds_o}), 64'({take, take}));
    chk(ud_o == ud, "R8", 64'(ud_o), 64'(ud));
    chk(cm_o == cmt, "R2", 64'(cm_o), 64'(cmt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    chk(dep_o == 0 && !act_o && !rv_o && !sv_o && !rr_o && !ds_o && !ud_o && !cm_o,
        "R12", 64'(dep_o), 64'h0);
    // R3 idle abort is a no-op
    op(0, 0, 1, 8'h55, 0, 1, 1, 0);
    // R2 end while idle
    op(0, 1, 0, 0, 0, 1, 1, 0);
    // R6 nested begins keep outermost fallback; R5 explicit status; R7 wide
    op(1, 0, 0, 0, 0, 1, 1, 64'hDEAD_BEEF_1234_5678);
    op(1, 0, 0, 0, 0, 1, 1, 64'h1111_2222_3333_4444);
    op(1, 0, 0, 0, 0, 1, 1, 64'h5555_6666_7777_8888);
    op(0, 0, 1, 8'hA7, 0, 1, 1, 0);
    // R7 narrow mode masks upper half
    op(1, 0, 0, 0, 0, 1, 0, 64'hCAFE_F00D_9ABC_DEF0);
    op(0, 0, 1, 8'h3C, 0, 1, 0, 0);
    // R8 lock prefix and feature off while active
    op(1, 0, 0, 0, 0, 1, 1, 64'h0123_4567_89AB_CDEF);
    op(0, 0, 1, 8'hFF, 1, 1, 1, 0);
    op(0, 0, 1, 8'hFF, 0, 0, 1, 0);
    // R2 commit at outermost end
    op(0, 1, 0, 0, 0, 1, 1, 0);
    // R10 overflow at depth 7
    for (int i = 0; i < 7; i++) op(1, 0, 0, 0, 0, 1, 1, 64'h100 + 64'(i));
    op(1, 0, 0, 8'h99, 0, 1, 1, 64'hFFFF);
    // R11 precedence: abort beats end and begin, end beats begin
    op(1, 0, 0, 0, 0, 1, 1, 64'h4000);
    op(1, 0, 0, 0, 0, 1, 1, 64'h5000);
    op(1, 1, 0, 0, 0, 1, 1, 64'h6000);
    op(1, 1, 1, 8'h42, 0, 1, 1, 64'h7000);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic b, e, a;
      r = int'($urandom_range(0, 99));
      b = (r < 40); e = (r >= 40 && r < 65); a = (r >= 65 && r < 80);
      if ($urandom_range(0, 19) == 0) e = 1'b1;
      op(b, e, a, 8'($urandom), $urandom_range(0, 9) == 0, $urandom_range(0, 9) != 0,
         1'($urandom), {$urandom, $urandom});
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule